// File: doc/BRIEF.md
# Recirculating Page Data Register

This block is a one-page holding buffer that sits between a serial data path and a parallel page array. Bits enter one at a time at the tail of the buffer and leave one at a time from its head, so the buffer acts as a first-in first-out store. When a bit is read out it is also fed back in at the tail. A full-page readout therefore leaves the contents unchanged, and a partial readout only rotates them.

A transfer begins with a start pulse. The pulse carries a direction and a count argument, and the transfer then moves the argument plus one bits, one bit per strobe on the bit-enable input. The array side has a single-cycle parallel load, which fills the buffer, and a single-cycle parallel store, which captures it. Neither fires while a serial transfer is running. While the array reports busy, the block refuses new transfers and ignores bit strobes. The contents carry no reset value, and nothing clears them between transfers, so a page can be assembled from several partial shift-ins.

Top module: `pdr_page_reg`

## Requirements
- R1: After reset, `xfer_active_o`, `done_o` and `store_valid_o` are all 0.
- R2: A start accepted while idle and not busy moves exactly `cnt_i`+1 bits (a `cnt_i` of 0 moves one bit, 255 moves 256 bits). `done_o` is 1 for the single cycle after the last bit moves, and `xfer_active_o` drops in that same cycle.
- R3: In shift-in mode (`dir_i`=0), each strobe puts `din_i` at the tail. `dout_o` always shows the head, and after 256 shift-ins the first bit written is the first bit read out.
- R4: In shift-out mode (`dir_i`=1), each strobe moves the head bit back to the tail, and a 256-bit readout leaves the page unchanged.
- R5: After a k-bit shift-in, a full readout first returns the 256-k bits that were already held, oldest first, and then the k new bits in the order they arrived.
- R6: While `busy_i` is 1, a start is ignored and bit strobes neither move data nor advance the count. The transfer resumes once `busy_i` returns to 0.
- R7: A start pulse that arrives during a transfer is ignored. It changes neither the remaining count nor the direction.
- R8: With no transfer active, `load_i` copies `load_data_i` into the page in one cycle. Bit 255 of the parallel word is the head, bit 0 the tail. `load_i` is ignored during a transfer, and a start in the same cycle as a load is ignored.
- R9: With no transfer active, `store_i` makes `store_valid_o` 1 in the next cycle, with `store_data_o` holding the page as it stood when `store_i` was sampled, using the bit order of R8. During a transfer `store_i` is ignored.
- R10: While no transfer is active, bit strobes and `din_i` leave the page unchanged.
- R11: The page keeps its contents between transfers. Four 64-bit shift-ins in a row therefore leave the first segment at the head and the last segment at the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the control state; page contents are not reset |
| busy_i | input | 1 | Array busy; blocks starts and bit strobes |
| start_i | input | 1 | Start a serial transfer |
| dir_i | input | 1 | Transfer direction: 0 shift-in, 1 shift-out |
| cnt_i | input | 8 | Bit count argument, one less than the bits to move |
| bit_en_i | input | 1 | Bit strobe, one bit per cycle it is high |
| din_i | input | 1 | Serial data in |
| dout_o | output | 1 | Head bit of the page |
| xfer_active_o | output | 1 | Serial transfer in progress |
| done_o | output | 1 | One-cycle pulse after the last bit of a transfer |
| load_i | input | 1 | Parallel load from the array |
| load_data_i | input | 256 | Parallel load data, bit 255 is the head |
| store_i | input | 1 | Parallel store request toward the array |
| store_valid_o | output | 1 | Store data valid |
| store_data_o | output | 256 | Captured page, bit 255 is the head |

## Verification
The assertions assume that `busy_i`, the strobes and the requests are driven synchronously and that a load and a store are never requested in the same cycle as an accepted start. The bench changes every input only on the falling clock edge. It never raises `load_i` together with a start it wants accepted, and it tests the collision cases on purpose. Bit strobes appear with gaps, while idle, and during busy, so each blocking rule is exercised by stimulus that stays within those assumptions.

// File: rtl/pdr_pkg.sv
package pdr_pkg;

  typedef enum logic {
    XFER_IN  = 1'b0,
    XFER_OUT = 1'b1
  } xfer_dir_e;

  // Number of bits a transfer moves for a given count argument.
  function automatic int unsigned xfer_bits(input int unsigned arg);
    return arg + 1;
  endfunction

  // Bit entering the tail: fresh input or the recirculated head.
  function automatic logic feed_bit(input xfer_dir_e dir, input logic head, input logic din);
    return (dir == XFER_OUT) ? head : din;
  endfunction

endpackage

// File: rtl/pdr_xfer_ctl.sv
module pdr_xfer_ctl
  import pdr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             dir_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             bit_en_i,
  input  logic             busy_i,
  input  logic             hold_i,
  output logic             active_o,
  output xfer_dir_e        dir_o,
  output logic             shift_fire_o,
  output logic             done_o
);

  logic [CNT_W-1:0] remain_q;
  logic             start_fire;
  logic             last_fire;

  assign start_fire   = start_i & ~active_o & ~busy_i & ~hold_i;
  assign shift_fire_o = active_o & bit_en_i & ~busy_i;
  assign last_fire    = shift_fire_o & (remain_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      remain_q <= '0;
      dir_o    <= XFER_IN;
      done_o   <= 1'b0;
    end else begin
      done_o <= last_fire;
      if (start_fire) begin
        active_o <= 1'b1;
        remain_q <= cnt_i;
        dir_o    <= xfer_dir_e'(dir_i);
      end else if (shift_fire_o) begin
        if (last_fire) active_o <= 1'b0;
        else           remain_q <= remain_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/pdr_shift_core.sv
module pdr_shift_core #(
  parameter int PAGE_BITS = 256
) (
  input  logic                 clk,
  input  logic                 load_en_i,
  input  logic [PAGE_BITS-1:0] load_data_i,
  input  logic                 shift_en_i,
  input  logic                 feed_i,
  output logic [PAGE_BITS-1:0] page_o
);

  // Bit 0 is the tail, bit PAGE_BITS-1 the head; a shift moves toward the head.
  for (genvar k = 0; k < PAGE_BITS; k++) begin : g_cell
    logic nxt;
    if (k == 0) begin : g_tail
      assign nxt = feed_i;
    end else begin : g_body
      assign nxt = page_o[k-1];
    end
    always_ff @(posedge clk) begin
      if (load_en_i)       page_o[k] <= load_data_i[k];
      else if (shift_en_i) page_o[k] <= nxt;
    end
  end

endmodule

// File: rtl/pdr_store_port.sv
module pdr_store_port #(
  parameter int PAGE_BITS = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire_i,
  input  logic [PAGE_BITS-1:0] page_i,
  output logic                 valid_o,
  output logic [PAGE_BITS-1:0] data_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_o <= 1'b0;
    else        valid_o <= fire_i;
  end

  always_ff @(posedge clk) begin
    if (fire_i) data_o <= page_i;
  end

endmodule

// File: rtl/pdr_page_reg.sv
module pdr_page_reg
  import pdr_pkg::*;
#(
  parameter  int PAGE_BITS = 256,
  localparam int CNT_W     = $clog2(PAGE_BITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 busy_i,
  input  logic                 start_i,
  input  logic                 dir_i,
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic                 bit_en_i,
  input  logic                 din_i,
  output logic                 dout_o,
  output logic                 xfer_active_o,
  output logic                 done_o,
  input  logic                 load_i,
  input  logic [PAGE_BITS-1:0] load_data_i,
  input  logic                 store_i,
  output logic                 store_valid_o,
  output logic [PAGE_BITS-1:0] store_data_o
);

  // Named internal events, observed by the bound checker.
  logic [PAGE_BITS-1:0] page_q;
  logic                 shift_fire_w;
  logic                 load_fire_w;
  logic                 store_fire_w;
  logic                 feed_w;
  xfer_dir_e            dir_q;

  assign load_fire_w  = load_i & ~xfer_active_o;
  assign store_fire_w = store_i & ~xfer_active_o;
  assign dout_o       = page_q[PAGE_BITS-1];
  assign feed_w       = feed_bit(dir_q, page_q[PAGE_BITS-1], din_i);

  pdr_xfer_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .dir_i        (dir_i),
    .cnt_i        (cnt_i),
    .bit_en_i     (bit_en_i),
    .busy_i       (busy_i),
    .hold_i       (load_i),
    .active_o     (xfer_active_o),
    .dir_o        (dir_q),
    .shift_fire_o (shift_fire_w),
    .done_o       (done_o)
  );

  pdr_shift_core #(.PAGE_BITS(PAGE_BITS)) u_core (
    .clk         (clk),
    .load_en_i   (load_fire_w),
    .load_data_i (load_data_i),
    .shift_en_i  (shift_fire_w),
    .feed_i      (feed_w),
    .page_o      (page_q)
  );

  pdr_store_port #(.PAGE_BITS(PAGE_BITS)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire_i  (store_fire_w),
    .page_i  (page_q),
    .valid_o (store_valid_o),
    .data_o  (store_data_o)
  );

endmodule

// File: rtl/pdr_page_reg_chk.sv
module pdr_page_reg_chk
  import pdr_pkg::*;
#(
  parameter int PAGE_BITS = 256
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 busy_i,
  input logic                 store_i,
  input logic [PAGE_BITS-1:0] load_data_i,
  input logic                 xfer_active_o,
  input logic                 done_o,
  input logic                 store_valid_o,
  input logic [PAGE_BITS-1:0] store_data_o,
  input logic [PAGE_BITS-1:0] page_q,
  input logic                 shift_fire_w,
  input logic                 load_fire_w,
  input xfer_dir_e            dir_q
);

  assert_done_on_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_active_o) |-> done_o);

  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !xfer_active_o);

  assert_recirc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_fire_w && dir_q == XFER_OUT) |=>
      page_q == {$past(page_q[PAGE_BITS-2:0]), $past(page_q[PAGE_BITS-1])});

  assert_busy_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !load_fire_w) |=> $stable(page_q));

  assert_fire_needs_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
    shift_fire_w |-> (xfer_active_o && !busy_i));

  assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire_w |=> page_q == $past(load_data_i));

  assert_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    store_valid_o |-> ($past(store_i) && !$past(xfer_active_o) && store_data_o == $past(page_q)));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_active_o && !load_fire_w) |=> $stable(page_q));

endmodule

bind pdr_page_reg pdr_page_reg_chk #(.PAGE_BITS(PAGE_BITS)) u_chk (.*);

// File: tb/sim_pdr_page_reg.sv
`timescale 1ns/1ps
module sim_pdr_page_reg;
  localparam int W  = 256;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          busy_i = 1'b0, start_i = 1'b0, dir_i = 1'b0, bit_en_i = 1'b0, din_i = 1'b0;
  logic [CW-1:0] cnt_i = '0;
  logic          load_i = 1'b0, store_i = 1'b0;
  logic [W-1:0]  load_data_i = '0;
  logic          dout_o, xfer_active_o, done_o, store_valid_o;
  logic [W-1:0]  store_data_o;

  pdr_page_reg #(.PAGE_BITS(W)) u0 (
    .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .start_i(start_i), .dir_i(dir_i),
    .cnt_i(cnt_i), .bit_en_i(bit_en_i), .din_i(din_i), .dout_o(dout_o),
    .xfer_active_o(xfer_active_o), .done_o(done_o), .load_i(load_i),
    .load_data_i(load_data_i), .store_i(store_i), .store_valid_o(store_valid_o),
    .store_data_o(store_data_o)
  );

  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit           m_q[$];
  bit           m_known = 0;
  bit           m_active = 0, m_dir = 0, m_done = 0, m_sv = 0;
  int           m_rem = 0;
  logic [W-1:0] m_sd;
  bit           f_load, f_start, f_shift, f_store, m_b;

  function automatic logic [W-1:0] model_vec();
    logic [W-1:0] v;
    for (int i = 0; i < W; i++) v[W-1-i] = m_q[i];
    return v;
  endfunction

  initial for (int i = 0; i < W; i++) m_q.push_back(1'b0);

  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0; m_done = 0; m_sv = 0; m_rem = 0;
    end else begin
      f_load  = load_i && !m_active;
      f_start = start_i && !m_active && !busy_i && !load_i;
      f_shift = m_active && bit_en_i && !busy_i;
      f_store = store_i && !m_active;
      m_sv    = f_store;
      if (f_store) m_sd = model_vec();
      m_done  = f_shift && (m_rem == 0);
      if (f_shift) begin
        m_b = m_dir ? m_q[0] : din_i;
        void'(m_q.pop_front());
        m_q.push_back(m_b);
        if (m_rem == 0) m_active = 0; else m_rem--;
      end
      if (f_start) begin m_active = 1; m_rem = int'(cnt_i); m_dir = dir_i; end
      if (f_load) begin
        for (int i = 0; i < W; i++) m_q[i] = load_data_i[W-1-i];
        m_known = 1;
      end
    end
  end

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(xfer_active_o == m_active, "R2", "active", W'(xfer_active_o), W'(m_active));
      chk(done_o == m_done, "R2", "done", W'(done_o), W'(m_done));
      chk(store_valid_o == m_sv, "R9", "store_valid", W'(store_valid_o), W'(m_sv));
      if (m_sv) chk(store_data_o == m_sd, "R9", "store_data", store_data_o, m_sd);
      if (m_known) chk(dout_o == m_q[0], "R3", "head bit", W'(dout_o), W'(m_q[0]));
    end
  end

  // ---------------- stimulus helpers ----------------
  bit           cap[$];
  logic [W-1:0] cur, s, g, e, p;

  task automatic tick(); @(negedge clk); endtask

  task automatic do_load(input logic [W-1:0] d);
    load_i = 1; load_data_i = d; tick(); load_i = 0;
  endtask

  task automatic do_store(output logic [W-1:0] d);
    store_i = 1; tick(); store_i = 0; d = store_data_o;
  endtask

  task automatic do_start(input bit dir, input int cnt);
    start_i = 1; dir_i = dir; cnt_i = CW'(cnt); tick(); start_i = 0;
  endtask

  // shift in n bits taken MSB-first from v; bench page tracked in cur
  task automatic shift_in_vec(input logic [W-1:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      din_i = v[W-1-i]; bit_en_i = 1; tick(); bit_en_i = 0;
      cur = {cur[W-2:0], v[W-1-i]};
      if (i % 5 == 4) tick();
    end
  endtask

  task automatic shift_out(input int n);
    cap = {};
    for (int i = 0; i < n; i++) begin
      cap.push_back(dout_o); bit_en_i = 1; tick(); bit_en_i = 0;
      cur = {cur[W-2:0], cur[W-1]};
    end
  endtask

  function automatic logic [W-1:0] cap_vec();
    logic [W-1:0] v;
    for (int i = 0; i < W; i++) v[W-1-i] = cap[i];
    return v;
  endfunction

  function automatic logic [W-1:0] pat(input int seed);
    logic [W-1:0] v;
    for (int i = 0; i < W/32; i++) v[i*32 +: 32] = (32'h9E3779B9 * (i + seed)) ^ 32'(seed * 7919);
    return v;
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // ---------------- scenarios ----------------
  initial begin
    repeat (3) tick();
    chk(xfer_active_o == 0 && done_o == 0 && store_valid_o == 0, "R1", "reset outputs",
        W'({xfer_active_o, done_o, store_valid_o}), '0);
    rst_n = 1; tick();

    // R8 / R9: parallel load then store
    p = pat(1); do_load(p); cur = p;
    do_store(s); chk(s == p, "R8", "load then store", s, p);

    // R4: full readout keeps contents and returns head first
    do_start(1, 255); shift_out(256); tick();
    g = cap_vec(); chk(g == p, "R4", "readout order", g, p);
    chk(xfer_active_o == 0, "R2", "idle after 256 bits", W'(xfer_active_o), '0);
    do_store(s); chk(s == p, "R4", "contents after readout", s, p);

    // R3: full shift-in, first bit in is first bit out
    p = pat(2); do_start(0, 255); shift_in_vec(p, 256); tick();
    do_store(s); chk(s == p, "R3", "page after full shift-in", s, p);
    do_start(1, 255); shift_out(256); tick();
    g = cap_vec(); chk(g == p, "R3", "fifo order", g, p);

    // R5: partial 40-bit shift-in, then full readout
    s = pat(3); do_start(0, 39); shift_in_vec(s, 40); tick();
    e = {p[W-41:0], s[W-1 -: 40]};
    do_start(1, 255); shift_out(256); tick();
    g = cap_vec(); chk(g == e, "R5", "older bits first", g, e);
    chk(cap[216] == s[W-1], "R5", "first new bit position", W'(cap[216]), W'(s[W-1]));

    // R11: page built from four 64-bit segments
    for (int k = 0; k < 4; k++) begin
      do_start(0, 63); shift_in_vec(pat(10 + k), 64); tick(); tick();
      e[W-1-64*k -: 64] = pat(10 + k) >> (W - 64);
    end
    do_store(s); chk(s == e, "R11", "segmented page", s, e);
    chk(s == cur, "R11", "bench page track", s, cur);

    // R6: busy blocks a start and freezes strobes
    busy_i = 1; do_start(1, 255); tick();
    chk(xfer_active_o == 0, "R6", "start while busy", W'(xfer_active_o), '0);
    busy_i = 0;
    p = pat(20); do_start(0, 15); shift_in_vec(p, 4);
    busy_i = 1; din_i = 1; bit_en_i = 1;
    g = W'(dout_o);
    repeat (5) tick();
    chk(W'(dout_o) == g && xfer_active_o == 1, "R6", "frozen during busy", W'({xfer_active_o, dout_o}), {g[W-2:0], 1'b1} | W'(2));
    busy_i = 0; bit_en_i = 0; tick();
    begin
      logic [W-1:0] rest;
      rest = p << 4;
      shift_in_vec(rest, 12);
    end
    tick();
    chk(xfer_active_o == 0, "R6", "count resumes after busy", W'(xfer_active_o), '0);
    do_store(s); chk(s == cur, "R6", "page after busy stall", s, cur);

    // R7 / R8 / R9: requests during a transfer are ignored
    p = pat(30); do_start(0, 7); shift_in_vec(p, 2);
    start_i = 1; dir_i = 1; cnt_i = 8'hFF; tick(); start_i = 0;
    load_i = 1; load_data_i = '1; tick(); load_i = 0;
    store_i = 1; tick(); store_i = 0;
    chk(store_valid_o == 0, "R9", "store ignored while active", W'(store_valid_o), '0);
    begin
      logic [W-1:0] rest;
      rest = p << 2;
      shift_in_vec(rest, 6);
    end
    tick();
    chk(xfer_active_o == 0, "R7", "second start ignored", W'(xfer_active_o), '0);
    do_store(s); chk(s == cur, "R8", "load ignored while active", s, cur);

    // R8: start in the same cycle as a load is ignored
    p = pat(40); start_i = 1; dir_i = 1; cnt_i = 8'd3; load_i = 1; load_data_i = p; tick();
    start_i = 0; load_i = 0; cur = p; tick();
    chk(xfer_active_o == 0, "R8", "start with load ignored", W'(xfer_active_o), '0);

    // R10: strobes while idle do nothing
    for (int i = 0; i < 10; i++) begin din_i = i[0]; bit_en_i = 1; tick(); end
    bit_en_i = 0;
    do_store(s); chk(s == cur, "R10", "idle strobes", s, cur);

    // R2: count argument 0 moves a single bit
    do_start(1, 0); bit_en_i = 1; repeat (3) tick(); bit_en_i = 0;
    cur = {cur[W-2:0], cur[W-1]}; tick();
    do_store(s); chk(s == cur, "R2", "one-bit transfer", s, cur);

    repeat (3) tick();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule